// File: doc/BRIEF.md
# Single-Bit Set, Clear and Test-Branch Executor

This block carries out the single-bit instructions of a small 8-bit processor. It can force one bit of a byte to one, force it to zero, or test it and branch on the result. The target byte always lies in the lowest 256 locations of the address space. Its address is the direct byte that follows the opcode. The surrounding fetch logic hands over the low opcode bits, the direct address byte, the signed relative byte (used only by the branch form) and the address of the opcode. It does this with a one-cycle start pulse.

The block reads the target byte over a synchronous memory port, where data returns one cycle after the read strobe. For set and clear it writes the byte back with only the chosen bit altered, and it leaves the condition codes alone. For test-and-branch it never writes memory. Instead it reports the tested bit for the carry flag and computes the address of the next instruction. That address is the fall-through address, or the fall-through address plus the sign-extended offset when the branch condition holds. Each instruction finishes with a one-cycle done pulse two cycles after it is accepted.

Top module: `bitop_exec`

## Requirements
- R1: While reset is asserted and whenever the block is idle, busy, done, mem_rd, mem_wr and carry_we are all low.
- R2: The opcode selector is five bits wide. Bit 4 picks the kind (0 = test-and-branch, 1 = set/clear). Bits 3:1 give the bit number n (0 to 7). Bit 0 gives the sense: for set/clear, 0 sets and 1 clears; for branch, 0 branches on a set bit and 1 branches on a clear bit.
- R3: In the cycle after start is accepted, mem_rd is high and mem_addr equals the direct address byte. In the cycle after that, done is high for exactly one cycle.
- R4: For set/clear, in the done cycle mem_wr is high, mem_addr is unchanged, and mem_wdata equals the byte that was read with only bit n forced to one (sense 0) or to zero (sense 1).
- R5: For set/clear, carry_we stays low and next_pc equals the opcode address plus 2, modulo 2^16.
- R6: For test-and-branch, memory is never written. In the done cycle carry_we is high and carry_out equals bit n of the byte that was read, whether or not the branch is taken.
- R7: For test-and-branch, next_pc is the opcode address plus 3 plus the sign-extended relative byte, modulo 2^16, when the condition holds. Otherwise it is the opcode address plus 3.
- R8: A start pulse that arrives while busy is high is ignored. The instruction in progress completes with its own operands.
- R9: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already released synchronously upstream |
| start | input | 1 | One-cycle request to execute an instruction |
| op_sel | input | 5 | Low opcode bits: kind, bit number, sense |
| op_dir | input | 8 | Direct address byte of the target |
| op_rel | input | 8 | Signed relative offset (branch form) |
| op_pc | input | 16 | Address of the opcode |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Result cycle of the current instruction |
| mem_addr | output | 8 | Memory address |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| carry_we | output | 1 | Carry flag write enable |
| carry_out | output | 1 | New carry value |
| next_pc | output | 16 | Address of the next instruction, valid with done |

## Verification
The bench builds the block with its default widths: 8-bit data, an 8-bit address and a 16-bit PC. With 8-bit data the whole selector space is only 32 codes, so every kind, every bit number and both senses are swept against complementary byte patterns. That means every bit position is seen both set and cleared, for every branch condition. The opcode addresses include values near 0xFFFF, and the offsets include the extreme positive and negative values. This brings the 16-bit wrap of the branch target and of the fall-through address within reach. Starts issued during the read cycle exercise the busy lockout.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ    = 2'd1,
    ST_RESOLVE = 2'd2
  } bitop_state_t;

  typedef enum logic {
    KIND_BRANCH = 1'b0,
    KIND_MODIFY = 1'b1
  } bitop_kind_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode #(
  parameter  int DATA_W = 8,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int SEL_W  = BIT_W + 2
) (
  input  logic [SEL_W-1:0]   sel,
  output bitop_pkg::bitop_kind_t kind,
  output logic               sense,
  output logic [BIT_W-1:0]   bit_idx
);

  always_comb begin
    kind    = bitop_pkg::bitop_kind_t'(sel[SEL_W-1]);
    bit_idx = sel[BIT_W:1];
    sense   = sel[0];
  end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu #(
  parameter  int DATA_W = 8,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              sense,
  output logic [DATA_W-1:0] wdata,
  output logic              tested,
  output logic              cond_met
);

  logic [DATA_W-1:0] mask;

  always_comb begin
    mask = '0;
    mask[bit_idx] = 1'b1;
    // sense 0 forces the bit high, sense 1 forces it low
    if (sense) wdata = rdata & ~mask;
    else       wdata = rdata | mask;
    tested   = rdata[bit_idx];
    // branch when bit set (sense 0) or bit clear (sense 1)
    cond_met = tested ^ sense;
  end

endmodule

// File: rtl/bitop_target.sv
module bitop_target #(
  parameter int PC_W  = 16,
  parameter int REL_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [REL_W-1:0] rel,
  input  logic             is_branch,
  input  logic             taken,
  output logic [PC_W-1:0]  next_pc
);

  localparam int EXT_W = PC_W - REL_W;

  logic [PC_W-1:0] len;
  logic [PC_W-1:0] disp;

  always_comb begin
    len     = is_branch ? PC_W'(3) : PC_W'(2);
    disp    = taken ? {{EXT_W{rel[REL_W-1]}}, rel} : '0;
    next_pc = pc + len + disp;
  end

endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic in_read,
  output logic in_resolve
);

  bitop_pkg::bitop_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      bitop_pkg::ST_IDLE:    if (start) state_d = bitop_pkg::ST_READ;
      bitop_pkg::ST_READ:    state_d = bitop_pkg::ST_RESOLVE;
      bitop_pkg::ST_RESOLVE: state_d = bitop_pkg::ST_IDLE;
      default:               state_d = bitop_pkg::ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= bitop_pkg::ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    busy       = (state_q != bitop_pkg::ST_IDLE);
    accept     = start && !busy;
    in_read    = (state_q == bitop_pkg::ST_READ);
    in_resolve = (state_q == bitop_pkg::ST_RESOLVE);
  end

endmodule

// File: rtl/bitop_exec.sv
module bitop_exec #(
  parameter  int DATA_W = 8,
  parameter  int ADDR_W = 8,
  parameter  int PC_W   = 16,
  parameter  int REL_W  = 8,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int SEL_W  = BIT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  op_sel,
  input  logic [ADDR_W-1:0] op_dir,
  input  logic [REL_W-1:0]  op_rel,
  input  logic [PC_W-1:0]   op_pc,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              carry_we,
  output logic              carry_out,
  output logic [PC_W-1:0]   next_pc
);

  logic accept, in_read, in_resolve;

  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] dir_q;
  logic [REL_W-1:0]  rel_q;
  logic [PC_W-1:0]   pc_q;

  bitop_pkg::bitop_kind_t kind;
  logic              sense;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] alu_wdata;
  logic              tested, cond_met;
  logic              is_branch;

  bitop_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .accept     (accept),
    .busy       (busy),
    .in_read    (in_read),
    .in_resolve (in_resolve)
  );

  // operand capture, enabled only when a start is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      dir_q <= '0;
      rel_q <= '0;
      pc_q  <= '0;
    end else if (accept) begin
      sel_q <= op_sel;
      dir_q <= op_dir;
      rel_q <= op_rel;
      pc_q  <= op_pc;
    end
  end

  bitop_decode #(.DATA_W(DATA_W)) u_dec (
    .sel     (sel_q),
    .kind    (kind),
    .sense   (sense),
    .bit_idx (bit_idx)
  );

  bitop_alu #(.DATA_W(DATA_W)) u_alu (
    .rdata    (mem_rdata),
    .bit_idx  (bit_idx),
    .sense    (sense),
    .wdata    (alu_wdata),
    .tested   (tested),
    .cond_met (cond_met)
  );

  assign is_branch = (kind == bitop_pkg::KIND_BRANCH);

  bitop_target #(.PC_W(PC_W), .REL_W(REL_W)) u_tgt (
    .pc        (pc_q),
    .rel       (rel_q),
    .is_branch (is_branch),
    .taken     (is_branch && cond_met),
    .next_pc   (next_pc)
  );

  always_comb begin
    mem_addr  = dir_q;
    mem_rd    = in_read;
    mem_wr    = in_resolve && !is_branch;
    mem_wdata = alu_wdata;
    done      = in_resolve;
    carry_we  = in_resolve && is_branch;
    carry_out = tested;
  end

endmodule

// File: rtl/bitop_exec_chk.sv
module bitop_exec_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              carry_we
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!done && !mem_rd && !mem_wr && !carry_we));

  assert_read_follows_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> mem_rd);

  assert_done_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (done && !mem_rd));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_one_bit_changed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

  assert_write_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == $past(mem_addr)));

  assert_no_carry_on_modify_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !carry_we);

  assert_branch_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_we |-> (done && !mem_wr));

  assert_busy_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mem_rd) |=> !mem_rd);

  assert_rd_wr_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

bind bitop_exec bitop_exec_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bitop_exec_tb.sv
module bitop_exec_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [7:0]  op_dir = '0;
  logic [7:0]  op_rel = '0;
  logic [15:0] op_pc = '0;
  logic        busy, done, mem_rd, mem_wr, carry_we, carry_out;
  logic [7:0]  mem_addr, mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] next_pc;

  logic [7:0]  mem [256];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bitop_exec u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .op_dir(op_dir),
    .op_rel(op_rel), .op_pc(op_pc), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .carry_we(carry_we), .carry_out(carry_out), .next_pc(next_pc)
  );

  // synchronous memory model
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [4:0] sel, input logic [7:0] dir,
                        input logic [7:0] rel, input logic [15:0] pc,
                        input logic [7:0] data, input bit disturb);
    logic [2:0]  n;
    logic        sense, modify, b, taken;
    logic [7:0]  exp_byte;
    logic [15:0] exp_pc;
    n = sel[3:1];
    sense = sel[0];
    modify = sel[4];
    b = data[n];
    if (modify) begin
      exp_byte = sense ? (data & ~(8'd1 << n)) : (data | (8'd1 << n));
      exp_pc = pc + 16'd2;
    end else begin
      exp_byte = data;
      taken = b ^ sense;
      exp_pc = pc + 16'd3 + (taken ? {{8{rel[7]}}, rel} : 16'd0);
    end
    mem[dir] = data;
    start = 1'b1; op_sel = sel; op_dir = dir; op_rel = rel; op_pc = pc;
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd && mem_addr == dir && !done, "R3 read cycle", {23'd0, mem_rd, mem_addr},
        {24'd1, dir});
    if (disturb) begin
      // R8: a second request while busy must be ignored
      start = 1'b1; op_sel = ~sel; op_dir = dir + 8'd1; op_rel = ~rel; op_pc = ~pc;
    end
    @(negedge clk);
    start = 1'b0;
    chk(done, "R3 done cycle", {31'd0, done}, 32'd1);
    if (modify) begin
      chk(mem_wr && mem_wdata == exp_byte && mem_addr == dir, "R4 write data",
          {23'd0, mem_wr, mem_wdata}, {24'd1, exp_byte});
      chk(!carry_we && next_pc == exp_pc, "R5 pc and flags",
          {15'd0, carry_we, next_pc}, {16'd0, exp_pc});
    end else begin
      chk(!mem_wr && carry_we && carry_out == b, "R6 carry and no write",
          {29'd0, mem_wr, carry_we, carry_out}, {30'd1, b});
      chk(next_pc == exp_pc, "R7 branch target", {16'd0, next_pc}, {16'd0, exp_pc});
    end
    @(negedge clk);
    chk(!busy && !done && !mem_rd, "R1 idle after done", {29'd0, busy, done, mem_rd}, 32'd0);
    chk(mem[dir] == exp_byte, modify ? "R4 stored byte" : "R6 byte untouched",
        {24'd0, mem[dir]}, {24'd0, exp_byte});
    if (disturb)
      chk(mem[dir + 8'd1] == 8'h3C, "R8 neighbour untouched", {24'd0, mem[dir + 8'd1]},
          32'h3C);
  endtask

  initial begin
    logic [7:0]  pats [4];
    logic [7:0]  rels [4];
    logic [15:0] pcs  [4];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    rels = '{8'h00, 8'h7F, 8'h80, 8'hFE};
    pcs  = '{16'hFFFE, 16'h0001, 16'h8000, 16'h1234};
    for (int i = 0; i < 256; i++) mem[i] = 8'h3C;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr && !carry_we, "R1 reset state",
        {27'd0, busy, done, mem_rd, mem_wr, carry_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_rd && !mem_wr, "R1 idle after reset", {29'd0, busy, mem_rd, mem_wr}, 32'd0);
    // R2: sweep every selector code, bit number and sense
    for (int op = 0; op < 32; op++) begin
      for (int d = 0; d < 4; d++) begin
        run_op(op[4:0], 8'(op * 7 + d * 2), rels[(op + d) % 4], pcs[(op * 3 + d) % 4],
               pats[d], d == 2);
        mem[8'(op * 7 + d * 2 + 1)] = 8'h3C;
      end
    end
    // R7: wrap of the taken target below zero and of the fall-through past 0xFFFF
    run_op(5'b00000, 8'hF0, 8'h80, 16'h0010, 8'h01, 1'b0);
    run_op(5'b00001, 8'hF1, 8'h10, 16'hFFFD, 8'h01, 1'b0);
    // R9 is checked by the bound checker throughout
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule